// File: doc/BRIEF.md
# Link Retry Sequencer With Test Controls

This block runs the link-level recovery of a packetized serial memory link. While the link is healthy it lets normal traffic through. When the receive side flags a damaged input stream, it first sends a single start-retry request toward the far end. It then sends a fixed burst of idle-retry packets and counts the idle-retry packets that come back. Once enough have arrived, it returns to normal traffic. If the far end stays silent for longer than a programmable wait, the block starts the recovery again. After a fixed number of such attempts it gives up and parks in a fatal state.

Three test hooks are driven as one-cycle pulses from a control register. The first forces a retry exactly as a detected stream error would. The second arms a one-time corruption of the CRC of the next normal request: the block outputs a mask that the CRC path XORs into that request. The third releases the machine from the fatal state. The block also keeps a saturating count of completed recoveries.

The machine has six states. IDLE (code 0) carries normal traffic. START (1) sends the start-retry request. TXIR (2) sends the idle-retry burst. WAITRX (3) waits for the returning idle-retry packets. DONE (4) closes a successful recovery. FATAL (5) holds a link that has given up.

The transitions are:
- IDLE to START on an error or forced retry.
- START to TXIR always.
- TXIR to WAITRX after the last burst packet.
- WAITRX to DONE when the receive count is complete.
- WAITRX to START on a timeout while attempts remain.
- WAITRX to FATAL on a timeout once the attempts are used up.
- DONE to IDLE always.
- FATAL to IDLE on the release pulse.

Top module: `lnk_retry_seq`

## Requirements
- R1: In IDLE, `tx_sel_o` is 0 (normal). A pulse on `err_det_i` or `ctl_force_retry_i` in IDLE moves the block to START at the next clock edge. START lasts exactly one cycle, with `tx_sel_o` = 1 (start-retry request).
- R2: After START the block stays in TXIR for exactly TX_N (32) consecutive cycles with `tx_sel_o` = 2 (idle-retry packet). It then enters WAITRX, where `tx_sel_o` = 3 (null).
- R3: Pulses on `rx_irtry_i` are counted in START, TXIR and WAITRX, and the count is cleared in IDLE. A pulse is seen by the machine one cycle after it arrives. The first WAITRX cycle in which the count has reached RX_N (20) is followed by one DONE cycle (`tx_sel_o` = 3) and then IDLE.
- R4: WAITRX ends in a timeout when the count is still below RX_N in the WAITRX cycle where `timeout_cfg_i` cycles have already passed in WAITRX (that is, WAITRX cycle number `timeout_cfg_i`+1). While attempts remain, a timeout returns the block to START and clears the receive count. When completion and timeout fall in the same cycle, completion wins.
- R5: The RETRY_LIMIT-th (3rd) timeout within one recovery moves the block to FATAL. In FATAL, `fatal_o` = 1 and `tx_sel_o` = 3.
- R6: FATAL is left only through a `ctl_exit_fatal_i` pulse, which moves the block to IDLE at the next edge. Error and forced-retry pulses in FATAL have no effect. A release pulse outside FATAL has no effect.
- R7: Error and forced-retry pulses in START, TXIR, WAITRX or DONE have no effect and do not add a start-retry request.
- R8: A `ctl_inject_crc_i` pulse arms the CRC fault. The next IDLE cycle with `tx_req_i` = 1 drives `crc_xor_o` = 1 (bit 0 only) in that same cycle and disarms the fault. `crc_xor_o` is 0 in every other cycle, and `tx_req_i` outside IDLE does not consume the fault. An arm pulse in the cycle that consumes the fault leaves it armed.
- R9: `retry_cnt_o` rises by one in the cycle after each DONE cycle. It stops at 2^STAT_W-1. Timeouts and FATAL do not change it.
- R10: After reset the block is in IDLE with `tx_sel_o` = 0, `crc_xor_o` = 0, `fatal_o` = 0, `retry_cnt_o` = 0, and the CRC fault disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_det_i | input | 1 | Input-stream error detected (pulse) |
| rx_irtry_i | input | 1 | One idle-retry packet received this cycle |
| tx_req_i | input | 1 | A normal request packet leaves this cycle |
| ctl_force_retry_i | input | 1 | Test hook: force a retry (pulse) |
| ctl_inject_crc_i | input | 1 | Test hook: arm a CRC bit-0 fault (pulse) |
| ctl_exit_fatal_i | input | 1 | Test hook: release the fatal state (pulse) |
| timeout_cfg_i | input | TMO_W | Wait limit in WAITRX, in cycles |
| tx_sel_o | output | 2 | Packet type to send: 0 normal, 1 start-retry, 2 idle-retry, 3 null |
| crc_xor_o | output | CRC_W | Mask XORed into the outgoing request CRC |
| state_o | output | 3 | State code (0 to 5 as listed above) |
| fatal_o | output | 1 | Block is in FATAL |
| retry_cnt_o | output | STAT_W | Completed recoveries, saturating |

## Verification
Two collisions are provoked on purpose. In the first, the wait limit is set to zero and all twenty idle-retry pulses are delivered during the burst. Completion and timeout then become due in the very first WAITRX cycle, and the bench expects DONE with no second start-retry request. In the second, an arm pulse is applied in the same cycle as a request that consumes an armed CRC fault. The bench expects the flip on that request and again on the following one. A behavioural model tracks state, packet select, CRC mask, fatal flag and the statistics count every cycle. This catches any wrong priority at the moment it happens.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_TXIR   = 3'd2,
        ST_WAITRX = 3'd3,
        ST_DONE   = 3'd4,
        ST_FATAL  = 3'd5
    } lrs_state_e;

    typedef enum logic [1:0] {
        SEL_NORMAL = 2'd0,
        SEL_START  = 2'd1,
        SEL_IRTRY  = 2'd2,
        SEL_NULL   = 2'd3
    } lrs_sel_e;

endpackage

// File: rtl/lrs_cnt.sv
// Saturating up-counter with synchronous clear; clear has priority.
module lrs_cnt #(
    parameter int unsigned W    = 8,
    parameter int unsigned MAXV = 255
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] val_o
);
    localparam logic [W-1:0] LIM = MAXV[W-1:0];

    logic [W-1:0] val_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (clr_i) begin
            val_q <= '0;
        end else if (inc_i && (val_q != LIM)) begin
            val_q <= val_q + 1'b1;
        end
    end

    assign val_o = val_q;

    // A counter at its limit never wraps (statistics saturation, R9)
    assert_hold_at_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (val_q == LIM && !clr_i) |=> (val_q == LIM));

endmodule

// File: rtl/lrs_crc_arm.sv
// One-shot CRC fault: armed by a pulse, fired on the next eligible request.
module lrs_crc_arm #(
    parameter int unsigned CRC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             req_i,
    output logic [CRC_W-1:0] flip_o
);
    logic armed_q;
    logic fire;

    assign fire   = armed_q & req_i;
    assign flip_o = fire ? {{(CRC_W-1){1'b0}}, 1'b1} : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= arm_i | (armed_q & ~fire);
        end
    end

    assert_single_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flip_o));

    assert_disarm_after_use_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|flip_o) && !arm_i) |=> !armed_q);

    assert_needs_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|flip_o) |-> req_i);

endmodule

// File: rtl/lnk_retry_seq.sv
module lnk_retry_seq
    import lrs_pkg::*;
#(
    parameter int unsigned TX_N        = 32,
    parameter int unsigned RX_N        = 20,
    parameter int unsigned RETRY_LIMIT = 3,
    parameter int unsigned TMO_W       = 16,
    parameter int unsigned STAT_W      = 16,
    parameter int unsigned CRC_W       = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_det_i,
    input  logic              rx_irtry_i,
    input  logic              tx_req_i,
    input  logic              ctl_force_retry_i,
    input  logic              ctl_inject_crc_i,
    input  logic              ctl_exit_fatal_i,
    input  logic [TMO_W-1:0]  timeout_cfg_i,
    output logic [1:0]        tx_sel_o,
    output logic [CRC_W-1:0]  crc_xor_o,
    output logic [2:0]        state_o,
    output logic              fatal_o,
    output logic [STAT_W-1:0] retry_cnt_o
);
    localparam int unsigned TXC_W = $clog2(TX_N + 1);
    localparam int unsigned RXC_W = $clog2(RX_N + 1);
    localparam int unsigned ATT_W = $clog2(RETRY_LIMIT + 1);
    localparam int unsigned TMO_MAX  = (2 ** TMO_W) - 1;
    localparam int unsigned STAT_MAX = (2 ** STAT_W) - 1;

    localparam logic [TXC_W-1:0] TX_LAST  = TXC_W'(TX_N - 1);
    localparam logic [RXC_W-1:0] RX_FULL  = RXC_W'(RX_N);
    localparam logic [ATT_W-1:0] ATT_LAST = ATT_W'(RETRY_LIMIT - 1);

    lrs_state_e state_q, state_d;
    lrs_sel_e   sel;

    logic [TXC_W-1:0] txc;
    logic [RXC_W-1:0] rxc;
    logic [TMO_W-1:0] tmr;
    logic [ATT_W-1:0] att;

    logic trig, in_idle, in_seq, tx_last, rx_done, tmo_hit;

    assign trig    = err_det_i | ctl_force_retry_i;
    assign in_idle = (state_q == ST_IDLE);
    assign in_seq  = (state_q == ST_START) || (state_q == ST_TXIR) || (state_q == ST_WAITRX);
    assign tx_last = (state_q == ST_TXIR) && (txc == TX_LAST);
    assign rx_done = (rxc == RX_FULL);
    assign tmo_hit = (state_q == ST_WAITRX) && !rx_done && (tmr >= timeout_cfg_i);

    // Burst length counter: cleared while sending the start-retry request
    lrs_cnt #(.W(TXC_W), .MAXV(TX_N)) u_txc (
        .clk(clk), .rst_n(rst_n),
        .clr_i(state_q == ST_START),
        .inc_i(state_q == ST_TXIR),
        .val_o(txc)
    );

    // Received idle-retry counter: cleared in IDLE and on every timeout
    lrs_cnt #(.W(RXC_W), .MAXV(RX_N)) u_rxc (
        .clk(clk), .rst_n(rst_n),
        .clr_i(in_idle | tmo_hit),
        .inc_i(rx_irtry_i & in_seq),
        .val_o(rxc)
    );

    // Wait timer: runs only in WAITRX
    lrs_cnt #(.W(TMO_W), .MAXV(TMO_MAX)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .clr_i(state_q != ST_WAITRX),
        .inc_i(state_q == ST_WAITRX),
        .val_o(tmr)
    );

    // Timeouts within the current recovery
    lrs_cnt #(.W(ATT_W), .MAXV(RETRY_LIMIT)) u_att (
        .clk(clk), .rst_n(rst_n),
        .clr_i(in_idle),
        .inc_i(tmo_hit),
        .val_o(att)
    );

    // Completed recoveries
    lrs_cnt #(.W(STAT_W), .MAXV(STAT_MAX)) u_stat (
        .clk(clk), .rst_n(rst_n),
        .clr_i(1'b0),
        .inc_i(state_q == ST_DONE),
        .val_o(retry_cnt_o)
    );

    // CRC fault: only a normal request in IDLE is a target
    lrs_crc_arm #(.CRC_W(CRC_W)) u_crc (
        .clk(clk), .rst_n(rst_n),
        .arm_i(ctl_inject_crc_i),
        .req_i(in_idle & tx_req_i),
        .flip_o(crc_xor_o)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (trig) state_d = ST_START;
            ST_START:  state_d = ST_TXIR;
            ST_TXIR:   if (tx_last) state_d = ST_WAITRX;
            ST_WAITRX: begin
                if (rx_done) begin
                    state_d = ST_DONE;
                end else if (tmo_hit) begin
                    state_d = (att == ATT_LAST) ? ST_FATAL : ST_START;
                end
            end
            ST_DONE:   state_d = ST_IDLE;
            ST_FATAL:  if (ctl_exit_fatal_i) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        sel     = SEL_NULL;
        fatal_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   sel = SEL_NORMAL;
            ST_START:  sel = SEL_START;
            ST_TXIR:   sel = SEL_IRTRY;
            ST_WAITRX: sel = SEL_NULL;
            ST_DONE:   sel = SEL_NULL;
            ST_FATAL:  begin
                sel     = SEL_NULL;
                fatal_o = 1'b1;
            end
            default:   sel = SEL_NULL;
        endcase
    end

    assign tx_sel_o = sel;
    assign state_o  = state_q;

    assert_start_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && $past(state_q) == ST_IDLE) |-> $past(trig));

    assert_start_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START) |=> (state_q == ST_TXIR));

    assert_burst_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_TXIR && state_q == ST_WAITRX) |-> ($past(txc) == TX_LAST));

    assert_done_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> ($past(rxc) == RX_FULL));

    assert_fatal_after_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_WAITRX && state_q == ST_FATAL) |-> ($past(att) == ATT_LAST));

    assert_fatal_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FATAL && !ctl_exit_fatal_i) |=> (state_q == ST_FATAL));

    assert_busy_ignores_trig_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TXIR && !tx_last) |=> (state_q == ST_TXIR));

endmodule

// File: tb/lnk_retry_seq_tb.sv
module lnk_retry_seq_tb;
    localparam int CLK_P    = 10;
    localparam int TX_N     = 32;
    localparam int RX_N     = 20;
    localparam int LIMIT    = 3;
    localparam int STAT_W   = 3;
    localparam int STAT_MAX = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic err_det = 0, rx_irtry = 0, tx_req = 0;
    logic f_retry = 0, inj = 0, x_fatal = 0;
    logic [7:0] tmo_cfg = 8'd10;
    logic [1:0] tx_sel;
    logic [31:0] crc_xor;
    logic [2:0] state;
    logic fatal;
    logic [STAT_W-1:0] rcnt;

    int total = 0, bad = 0, cycles = 0;
    int irtry_seen = 0, start_seen = 0;

    always #(CLK_P/2) clk = ~clk;

    lnk_retry_seq #(.TX_N(TX_N), .RX_N(RX_N), .RETRY_LIMIT(LIMIT), .TMO_W(8),
                    .STAT_W(STAT_W), .CRC_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .err_det_i(err_det), .rx_irtry_i(rx_irtry),
        .tx_req_i(tx_req), .ctl_force_retry_i(f_retry), .ctl_inject_crc_i(inj),
        .ctl_exit_fatal_i(x_fatal), .timeout_cfg_i(tmo_cfg), .tx_sel_o(tx_sel),
        .crc_xor_o(crc_xor), .state_o(state), .fatal_o(fatal), .retry_cnt_o(rcnt));

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int ms = 0, m_tx = 0, m_rx = 0, m_tmr = 0, m_att = 0, m_stat = 0;
    bit m_arm = 0;
    int ns, n_tx, n_rx, n_tmr, n_att, n_stat;
    bit tmo, fire, n_arm;

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; m_tx = 0; m_rx = 0; m_tmr = 0; m_att = 0; m_stat = 0; m_arm = 0;
        end else begin
            tmo  = (ms == 3) && (m_rx < RX_N) && (m_tmr >= int'(tmo_cfg));
            fire = m_arm && (ms == 0) && tx_req;
            ns = ms;
            case (ms)
                0: if (err_det || f_retry) ns = 1;
                1: ns = 2;
                2: if (m_tx == TX_N - 1) ns = 3;
                3: if (m_rx >= RX_N) ns = 4;
                   else if (tmo) ns = (m_att == LIMIT - 1) ? 5 : 1;
                4: ns = 0;
                5: if (x_fatal) ns = 0;
                default: ns = 0;
            endcase
            n_tx   = (ms == 1) ? 0 : (ms == 2) ? m_tx + 1 : m_tx;
            n_rx   = (ms == 0 || tmo) ? 0 :
                     (rx_irtry && ms >= 1 && ms <= 3 && m_rx < RX_N) ? m_rx + 1 : m_rx;
            n_tmr  = (ms == 3) ? m_tmr + 1 : 0;
            n_att  = (ms == 0) ? 0 : tmo ? m_att + 1 : m_att;
            n_stat = (ms == 4 && m_stat < STAT_MAX) ? m_stat + 1 : m_stat;
            n_arm  = inj || (m_arm && !fire);
            ms = ns; m_tx = n_tx; m_rx = n_rx; m_tmr = n_tmr;
            m_att = n_att; m_stat = n_stat; m_arm = n_arm;
        end
    end

    function automatic string st_tag(int s);
        case (s)
            0, 1: return "R1";
            2: return "R2";
            3, 4: return "R3";
            default: return "R5";
        endcase
    endfunction

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            chk(st_tag(ms), "state", int'(state), ms);
            chk(st_tag(ms), "tx_sel", int'(tx_sel), (ms == 0) ? 0 : (ms == 1) ? 1 : (ms == 2) ? 2 : 3);
            chk("R5", "fatal", int'(fatal), (ms == 5) ? 1 : 0);
            chk("R8", "crc_xor", int'(crc_xor), (m_arm && ms == 0 && tx_req) ? 1 : 0);
            chk("R9", "retry_cnt", int'(rcnt), m_stat);
            if (tx_sel == 2'd2) irtry_seen++;
            if (state == 3'd1) start_seen++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rx_burst(int n);
        repeat (n) begin
            @(negedge clk) rx_irtry = 1;
        end
        @(negedge clk) rx_irtry = 0;
    endtask

    task automatic p_err();   @(negedge clk) err_det = 1; @(negedge clk) err_det = 0; endtask
    task automatic p_force(); @(negedge clk) f_retry = 1; @(negedge clk) f_retry = 0; endtask
    task automatic p_inj();   @(negedge clk) inj = 1;     @(negedge clk) inj = 0;     endtask
    task automatic p_exit();  @(negedge clk) x_fatal = 1; @(negedge clk) x_fatal = 0; endtask

    int b_ir, b_st;

    initial begin
        cyc(3);
        rst_n = 1;
        #2;
        // R10 reset state
        chk("R10", "reset state", int'(state), 0);
        chk("R10", "reset tx_sel", int'(tx_sel), 0);
        chk("R10", "reset crc", int'(crc_xor), 0);
        chk("R10", "reset fatal", int'(fatal), 0);
        chk("R10", "reset count", int'(rcnt), 0);

        // Normal recovery triggered by an error
        b_ir = irtry_seen; b_st = start_seen;
        p_err();
        fork rx_burst(RX_N); join_none
        cyc(45); #2;
        chk("R1", "start requests", start_seen - b_st, 1);
        chk("R2", "idle-retry burst length", irtry_seen - b_ir, TX_N);
        chk("R3", "back in idle", int'(state), 0);
        chk("R9", "count after one", int'(rcnt), 1);

        // Timeout then success (R4)
        tmo_cfg = 8'd5;
        b_st = start_seen;
        p_force();
        fork rx_burst(RX_N - 1); join_none
        wait (start_seen - b_st == 2);
        cyc(1);
        fork rx_burst(RX_N); join_none
        cyc(45); #2;
        chk("R4", "restart after timeout", start_seen - b_st, 2);
        chk("R4", "idle after second attempt", int'(state), 0);
        chk("R9", "count after two", int'(rcnt), 2);

        // Completion and timeout due in the same cycle (R4)
        tmo_cfg = 8'd0;
        b_st = start_seen;
        p_err();
        fork rx_burst(RX_N); join_none
        cyc(45); #2;
        chk("R4", "completion wins", start_seen - b_st, 1);
        chk("R4", "count after collision", int'(rcnt), 3);

        // Exhaust attempts into FATAL (R5, R6)
        tmo_cfg = 8'd2;
        b_st = start_seen;
        p_force();
        cyc(130); #2;
        chk("R5", "fatal flag", int'(fatal), 1);
        chk("R5", "fatal state", int'(state), 5);
        chk("R5", "attempts made", start_seen - b_st, LIMIT);
        chk("R9", "count unchanged by fatal", int'(rcnt), 3);
        p_err(); p_force(); cyc(2); #2;
        chk("R6", "stays fatal", int'(state), 5);
        p_exit(); #2;
        chk("R6", "released to idle", int'(state), 0);
        chk("R6", "fatal cleared", int'(fatal), 0);
        p_exit(); #2;
        chk("R6", "release in idle ignored", int'(state), 0);

        // Triggers during a recovery are ignored (R7)
        tmo_cfg = 8'd10;
        b_st = start_seen;
        p_err();
        fork rx_burst(RX_N); join_none
        cyc(4);
        p_err(); p_force();
        cyc(45); #2;
        chk("R7", "single start request", start_seen - b_st, 1);
        chk("R7", "one more completion", int'(rcnt), 4);

        // CRC fault injection (R8)
        p_inj(); cyc(1); #2;
        chk("R8", "no flip without request", int'(crc_xor), 0);
        @(negedge clk) tx_req = 1; #2;
        chk("R8", "flip on next request", int'(crc_xor), 1);
        @(negedge clk); #2;
        chk("R8", "disarmed after use", int'(crc_xor), 0);
        tx_req = 0;
        p_err();
        fork rx_burst(RX_N); join_none
        p_inj();
        tx_req = 1;
        do begin @(negedge clk); #2; end while (state != 3'd0);
        chk("R8", "held through recovery then flip", int'(crc_xor), 1);
        @(negedge clk) tx_req = 0;
        p_inj();
        @(negedge clk) begin tx_req = 1; inj = 1; end
        #2;
        chk("R8", "flip with re-arm", int'(crc_xor), 1);
        @(negedge clk) inj = 0; #2;
        chk("R8", "re-armed flip", int'(crc_xor), 1);
        @(negedge clk); #2;
        chk("R8", "disarmed again", int'(crc_xor), 0);
        tx_req = 0;

        // Statistics saturation (R9)
        for (int i = 0; i < 5; i++) begin
            p_err();
            fork rx_burst(RX_N); join_none
            cyc(42);
        end
        #2;
        chk("R9", "saturated count", int'(rcnt), STAT_MAX);

        cyc(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule